// File: doc/BRIEF.md
# Strobe Watchdog with Selectable Timeout

This block supervises a processor by watching a strobe line that the processor's software pulses. A falling edge on the strobe is the only event that shows the processor is alive. Each such edge restarts a timeout count of millisecond ticks. If the count reaches the selected limit before another falling edge arrives, the block raises a one-cycle timeout request. A separate reset generator receives this request and stretches it into the system reset.

Counting happens only while the reset generator reports that reset is inactive. During reset the count is held at zero, so a newly released processor always gets a full period. The software picks the period with a two-bit code. Three fixed periods are available, nominally 150, 600 and 1200 ticks. The strobe is asynchronous, so it passes through a synchroniser before edge detection.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst_n` is low and in the cycles right after it is released, `tmo_req_o` is 0. The synchroniser resets to a high strobe level, so releasing reset never produces a falling edge by itself.
- R2: When `rst_inactive_i` is 0, the count is held at zero and `tmo_req_o` stays 0. Counting starts from zero in the first cycle that `rst_inactive_i` is 1.
- R3: A rising edge on the strobe does not affect the count, and neither does a strobe held steadily high or low.
- R4: A falling edge on `strobe_i` clears the count to zero. If the strobe is high at clock edge k-1 and low at clock edge k, the clear happens at edge k+2.
- R5: The code on `tmo_sel_i` sets the limit. 2'b00 selects SHORT_MS (150), 2'b01 selects MEDIUM_MS (600), and both 2'b10 and 2'b11 select LONG_MS (1200).
- R6: Suppose the count has reached limit-1 and a clock edge registers another tick with no clear. Then `tmo_req_o` is 1 for exactly the next cycle and the count restarts from zero.
- R7: A strobe low pulse lasting one clock period is detected as a falling edge.
- R8: If a clear and a tick fall on the same cycle, the clear wins and no request is issued.
- R9: Only cycles with `tick_1ms_i` at 1 advance the count. Gaps of any length between ticks do not change the number of ticks needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Asynchronous processor strobe; a falling edge restarts the timeout |
| tmo_sel_i | input | 2 | Timeout select code |
| rst_inactive_i | input | 1 | 1 while the reset generator's outputs are inactive |
| tick_1ms_i | input | 1 | One-cycle pulse per millisecond |
| tmo_req_o | output | 1 | One-cycle timeout request to the reset generator |

## Verification
A count that was wrongly cleared, or never cleared, can stay hidden for up to one full timeout period. It becomes visible at the ports only when `tmo_req_o` pulses one tick early, one tick late, or not at all. For this reason the bench compares `tmo_req_o` against a behavioural model on every cycle and drives strobe patterns that place expiries on exact ticks. A miscounted synchroniser latency shows up at the ports only when an edge coincides with an expiry tick, and the R8 pattern is built to produce that case.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    WDG_SEL_SHORT  = 2'b00,
    WDG_SEL_MEDIUM = 2'b01,
    WDG_SEL_LONG   = 2'b10,
    WDG_SEL_LONG2  = 2'b11
  } wdg_sel_e;

  // Limit in ticks for a select code; the spare code maps to the long period.
  function automatic int unsigned wdg_limit(input wdg_sel_e sel,
                                            input int unsigned short_ms,
                                            input int unsigned medium_ms,
                                            input int unsigned long_ms);
    case (sel)
      WDG_SEL_SHORT:  return short_ms;
      WDG_SEL_MEDIUM: return medium_ms;
      default:        return long_ms;
    endcase
  endfunction

endpackage

// File: rtl/wdg_strobe_edge.sv
module wdg_strobe_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // Reset to the idle-high level so release of reset yields no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int unsigned SHORT_MS  = 150,
  parameter int unsigned MEDIUM_MS = 600,
  parameter int unsigned LONG_MS   = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       clear_i,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  output logic       expire_o
);

  localparam int unsigned MAX_MS = (LONG_MS > MEDIUM_MS) ?
                                   ((LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS) :
                                   ((MEDIUM_MS > SHORT_MS) ? MEDIUM_MS : SHORT_MS);
  localparam int CNT_W = $clog2(MAX_MS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_inc;
  logic             hit;

  assign limit   = CNT_W'(wdg_limit(wdg_sel_e'(sel_i), SHORT_MS, MEDIUM_MS, LONG_MS));
  assign cnt_inc = cnt_q + 1'b1;
  assign hit     = (cnt_inc >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (!run_i || clear_i) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (tick_i) begin
      cnt_q    <= hit ? '0 : cnt_inc;
      expire_o <= hit;
    end else begin
      expire_o <= 1'b0;
    end
  end

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int unsigned SHORT_MS    = 150,
  parameter int unsigned MEDIUM_MS   = 600,
  parameter int unsigned LONG_MS     = 1200,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_i,
  input  logic [1:0] tmo_sel_i,
  input  logic       rst_inactive_i,
  input  logic       tick_1ms_i,
  output logic       tmo_req_o
);

  logic fall_w;

  wdg_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_i),
    .fall_o   (fall_w)
  );

  wdg_timer #(
    .SHORT_MS  (SHORT_MS),
    .MEDIUM_MS (MEDIUM_MS),
    .LONG_MS   (LONG_MS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (rst_inactive_i),
    .clear_i  (fall_w),
    .tick_i   (tick_1ms_i),
    .sel_i    (tmo_sel_i),
    .expire_o (tmo_req_o)
  );

endmodule

// File: rtl/strobe_watchdog_chk.sv
module strobe_watchdog_chk (
  input logic clk,
  input logic rst_n,
  input logic rst_inactive_i,
  input logic tick_1ms_i,
  input logic fall_w,
  input logic tmo_req_o
);

  // R6
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_req_o |=> !tmo_req_o);

  // R2
  no_req_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_inactive_i |=> !tmo_req_o);

  // R9
  req_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_1ms_i |=> !tmo_req_o);

  // R8
  clear_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_w |=> !tmo_req_o);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !tmo_req_o);

endmodule

bind strobe_watchdog strobe_watchdog_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rst_inactive_i (rst_inactive_i),
  .tick_1ms_i     (tick_1ms_i),
  .fall_w         (fall_w),
  .tmo_req_o      (tmo_req_o)
);

// File: tb/strobe_watchdog_tb_top.sv
module strobe_watchdog_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe_i = 1'b1;
  logic [1:0] tmo_sel_i = 2'b00;
  logic       rst_inactive_i = 1'b0;
  logic       tick_1ms_i = 1'b0;
  logic       tmo_req_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    tick_div = 1;
  int    tick_ph = 0;
  int    cyc = 0;
  int    n_req = 0;
  string phase = "R1";

  // model state
  logic  hist[$];
  int    m_cnt;
  logic  m_exp = 1'b0;
  bit    armed = 1'b0;

  always #10 clk = ~clk;

  strobe_watchdog dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe_i       (strobe_i),
    .tmo_sel_i      (tmo_sel_i),
    .rst_inactive_i (rst_inactive_i),
    .tick_1ms_i     (tick_1ms_i),
    .tmo_req_o      (tmo_req_o)
  );

  function automatic int lim_of(input logic [1:0] s);
    if (s == 2'b00) return 150;
    if (s == 2'b01) return 600;
    return 1200;
  endfunction

  // behavioural reference, updated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {1'b1, 1'b1, 1'b1};
      m_cnt = 0;
      m_exp = 1'b0;
    end else begin
      logic fall;
      fall = hist[0] & ~hist[1];
      if (!rst_inactive_i || fall) begin
        m_cnt = 0;
        m_exp = 1'b0;
      end else if (tick_1ms_i) begin
        if (m_cnt + 1 >= lim_of(tmo_sel_i)) begin
          m_cnt = 0;
          m_exp = 1'b1;
        end else begin
          m_cnt = m_cnt + 1;
          m_exp = 1'b0;
        end
      end else begin
        m_exp = 1'b0;
      end
      hist.push_back(strobe_i);
      void'(hist.pop_front());
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (armed) begin
      n_cmp++;
      if (tmo_req_o) n_req++;
      if (tmo_req_o !== m_exp) begin
        n_bad++;
        $display("FAIL %s cycle %0d: tmo_req_o actual=%b expected=%b",
                 phase, cyc, tmo_req_o, m_exp);
      end
    end
    tick_ph = (tick_ph + 1) % tick_div;
    tick_1ms_i <= (tick_ph == 0);
  end

  // period=0 holds strobe at idle; otherwise low for low_len of every period
  task automatic drive(input int n, input int period, input int low_len, input logic idle);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      strobe_i = (period > 0 && (i % period) < low_len) ? 1'b0 : ((period > 0) ? 1'b1 : idle);
    end
  endtask

  task automatic expect_pulses(input string tag, input int got, input int want);
    n_cmp++;
    if (got != want) begin
      n_bad++;
      $display("FAIL %s pulse count actual=%0d expected=%0d", tag, got, want);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    armed = 1'b1;
    // R1: reset state and release
    n_cmp++;
    if (tmo_req_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 in reset actual=%b expected=0", tmo_req_o);
    end
    rst_n = 1'b1;
    drive(6, 0, 0, 1'b1);

    // R2: held in reset, strobe toggling, no request
    phase = "R2"; n_req = 0;
    drive(2000, 37, 5, 1'b1);
    expect_pulses("R2", n_req, 0);
    rst_inactive_i = 1'b1;

    // R5/R6 short timeout, static high
    phase = "R6"; tmo_sel_i = 2'b00; n_req = 0;
    drive(460, 0, 0, 1'b1);
    expect_pulses("R6", n_req, 3);

    // R4: regular falling edges keep it quiet
    phase = "R4"; n_req = 0;
    drive(900, 100, 10, 1'b1);
    expect_pulses("R4", n_req, 0);

    // R3: steady low, then steady high with only rising edges
    phase = "R3"; n_req = 0;
    drive(400, 0, 0, 1'b0);
    drive(400, 0, 0, 1'b1);
    expect_pulses("R3", n_req, 5);

    // R7: one-cycle low pulses
    phase = "R7"; n_req = 0;
    drive(800, 120, 1, 1'b1);
    expect_pulses("R7", n_req, 0);

    // R8: edges landing on the expiry tick
    phase = "R8";
    for (int p = 148; p <= 152; p++) drive(700, p, 3, 1'b1);

    // R5: medium, long and spare code
    phase = "R5"; tmo_sel_i = 2'b01;
    drive(10, 1, 1, 1'b1);
    drive(1300, 0, 0, 1'b1);
    tmo_sel_i = 2'b10;
    drive(10, 1, 1, 1'b1);
    drive(2500, 0, 0, 1'b1);
    tmo_sel_i = 2'b11; n_req = 0;
    drive(10, 1, 1, 1'b1);
    drive(2500, 0, 0, 1'b1);
    expect_pulses("R5", n_req, 2);

    // R9: sparse ticks
    phase = "R9"; tmo_sel_i = 2'b00; tick_div = 3;
    drive(10, 1, 1, 1'b1);
    drive(1000, 0, 0, 1'b1);
    tick_div = 1;

    // R2: drop reset-inactive mid count, restart from zero
    phase = "R2"; rst_inactive_i = 1'b0;
    drive(50, 0, 0, 1'b1);
    rst_inactive_i = 1'b1;
    drive(400, 0, 0, 1'b1);

    armed = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired in phase %s actual=running expected=done", phase);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule